// File: doc/BRIEF.md
# Paired-Single Reduction Adder

This unit finishes a 4x4 matrix-vector transform by summing across the two single-precision lanes held inside each 64-bit paired-single operand. It does not add lane by lane between operands. The result packs the first operand's lane sum into its upper 32 bits and the second operand's lane sum into its lower 32 bits. Two identical single-precision adders work side by side. Each adder is split into four register stages: classify and swap, align and add, normalize, round and pack.

The unit has no stalls and takes a new operand pair on every clock. Two vertex computations can therefore be interleaved back to back. The output strobe is the input strobe delayed by the pipeline depth. Denormal operands are read as zeros of the same sign. Results too small to be normal are flushed to a zero that carries the result's sign. No exception flags are produced.

Top module: `ps_radd_top`

## Requirements
- R1: `res_o[63:32]` is the single-precision sum of `src_hi_i[63:32]` and `src_hi_i[31:0]`.
- R2: `res_o[31:0]` is the single-precision sum of `src_lo_i[63:32]` and `src_lo_i[31:0]`.
- R3: Each lane sum is rounded to nearest, and ties go to the even significand.
- R4: `valid_o` equals `valid_i` delayed by exactly 4 clock cycles. The data on `res_o` in that cycle belongs to the operands presented with that `valid_i`.
- R5: A new operand pair is accepted on every cycle. Back-to-back inputs give back-to-back results with no bubbles.
- R6: An operand with a zero exponent field is treated as a zero of its own sign. A rounded result whose biased exponent is 0 or below becomes a zero with the result's sign.
- R7: If either input of a lane is a NaN (exponent all ones, fraction non-zero), that lane outputs 0x7FC00000.
- R8: In a lane, infinity plus an infinity of the opposite sign gives 0x7FC00000. An infinity plus a finite value, or plus an infinity of the same sign, gives that infinity.
- R9: A sum that is exactly zero is +0 (0x00000000), except that two negative zeros give -0 (0x80000000).
- R10: A rounded result whose biased exponent reaches 255 becomes an infinity with the result's sign.
- R11: While `rst_ni` is low, `valid_o` is 0 and `res_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input operands present this cycle |
| src_hi_i | input | 64 | Operand whose lane sum goes to the upper result half |
| src_lo_i | input | 64 | Operand whose lane sum goes to the lower result half |
| valid_o | output | 1 | Result present this cycle |
| res_o | output | 64 | Packed pair of lane sums |

## Verification
Directed operands with distinct values in the two operands separate the upper-lane and lower-lane routing, which a swapped or lane-wise adder would get wrong. Ties below the last significand bit, with both even and odd neighbours, separate round-to-nearest-even from truncation or round-half-up. Near-cancelling pairs push the normalizer through long left shifts and into flushed underflow. Same-sign pairs with close exponents exercise the carry path and overflow to infinity. NaN, infinity, signed-zero and denormal operands each select a different special case. A long stream of pseudo-random operands, with `valid_i` toggling and with runs of consecutive inputs, checks the fixed latency and the every-cycle throughput against a wide-integer reference sum.

// File: rtl/ps_radd_pkg.sv
package ps_radd_pkg;
  localparam int unsigned FP_W     = 32;
  localparam int unsigned EXP_W    = 8;
  localparam int unsigned FRAC_W   = 23;
  localparam int unsigned GRD_W    = 3;
  localparam int unsigned MANT_W   = FRAC_W + 1 + GRD_W;  // hidden + frac + guard/round/sticky
  localparam int unsigned LZ_W     = $clog2(MANT_W + 1);
  localparam int unsigned SE_W     = EXP_W + 2;           // signed working exponent
  localparam int unsigned LANES    = 2;
  localparam int unsigned PS_W     = LANES * FP_W;
  localparam int unsigned PIPE_LAT = 4;
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam logic [FP_W-1:0]  QNAN    = 32'h7FC0_0000;

  function automatic logic fp_is_nan(input logic [FP_W-1:0] v);
    return (v[30:23] == EXP_MAX) && (v[22:0] != '0);
  endfunction

  function automatic logic fp_is_inf(input logic [FP_W-1:0] v);
    return (v[30:23] == EXP_MAX) && (v[22:0] == '0);
  endfunction

  function automatic logic fp_is_zero(input logic [FP_W-1:0] v);
    return v[30:23] == '0;  // denormals flushed
  endfunction

  function automatic logic [LZ_W-1:0] lzc(input logic [MANT_W-1:0] v);
    logic [LZ_W-1:0] c;
    logic            hit;
    c   = '0;
    hit = 1'b0;
    for (int i = MANT_W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (v[i]) hit = 1'b1;
        else      c   = c + 1'b1;
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/ps_valid_delay.sv
module ps_valid_delay #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[DEPTH-2:0], d_i};
  end

  assign q_o = sr_q[DEPTH-1];
endmodule

// File: rtl/fp32_add_pipe.sv
module fp32_add_pipe
  import ps_radd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FP_W-1:0] a_i,
  input  logic [FP_W-1:0] b_i,
  output logic [FP_W-1:0] sum_o
);
  // ---------------- stage 1: classify, order by magnitude
  logic            a_nan, b_nan, a_inf, b_inf, spec_c;
  logic [FP_W-1:0] spec_val_c, big_c, sml_c;
  logic [30:0]     a_mag, b_mag;

  always_comb begin
    a_nan = fp_is_nan(a_i);
    b_nan = fp_is_nan(b_i);
    a_inf = fp_is_inf(a_i);
    b_inf = fp_is_inf(b_i);
    spec_c = a_nan | b_nan | a_inf | b_inf;
    if (a_nan || b_nan || (a_inf && b_inf && (a_i[31] != b_i[31]))) spec_val_c = QNAN;
    else if (a_inf) spec_val_c = a_i;
    else            spec_val_c = b_i;
    a_mag = fp_is_zero(a_i) ? '0 : a_i[30:0];
    b_mag = fp_is_zero(b_i) ? '0 : b_i[30:0];
    if (b_mag > a_mag) begin
      big_c = {b_i[31], b_mag};
      sml_c = {a_i[31], a_mag};
    end else begin
      big_c = {a_i[31], a_mag};
      sml_c = {b_i[31], b_mag};
    end
  end

  logic              s1_sign, s1_sub, s1_zsign, s1_spec;
  logic [FP_W-1:0]   s1_spec_val;
  logic [EXP_W-1:0]  s1_exp, s1_diff;
  logic [MANT_W-1:0] s1_mb, s1_ms;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_sign <= 1'b0; s1_sub <= 1'b0; s1_zsign <= 1'b0; s1_spec <= 1'b0;
      s1_spec_val <= '0; s1_exp <= '0; s1_diff <= '0; s1_mb <= '0; s1_ms <= '0;
    end else begin
      s1_sign     <= big_c[31];
      s1_sub      <= a_i[31] ^ b_i[31];
      s1_zsign    <= a_i[31] & b_i[31];
      s1_spec     <= spec_c;
      s1_spec_val <= spec_val_c;
      s1_exp      <= big_c[30:23];
      s1_diff     <= big_c[30:23] - sml_c[30:23];
      s1_mb       <= (big_c[30:23] == '0) ? '0 : {1'b1, big_c[22:0], {GRD_W{1'b0}}};
      s1_ms       <= (sml_c[30:23] == '0) ? '0 : {1'b1, sml_c[22:0], {GRD_W{1'b0}}};
    end
  end

  // ---------------- stage 2: align smaller operand, add or subtract
  logic [MANT_W-1:0] shifted_c, lost_c, aligned_c;
  logic [MANT_W:0]   sum_c;

  always_comb begin
    if (s1_diff >= EXP_W'(MANT_W)) begin
      shifted_c = '0;
      lost_c    = s1_ms;
    end else begin
      shifted_c = s1_ms >> s1_diff;
      lost_c    = s1_ms & ~({MANT_W{1'b1}} << s1_diff);
    end
    aligned_c = {shifted_c[MANT_W-1:1], shifted_c[0] | (|lost_c)};
    sum_c = s1_sub ? ({1'b0, s1_mb} - {1'b0, aligned_c})
                   : ({1'b0, s1_mb} + {1'b0, aligned_c});
  end

  logic              s2_sign, s2_zsign, s2_spec;
  logic [FP_W-1:0]   s2_spec_val;
  logic [EXP_W-1:0]  s2_exp;
  logic [MANT_W:0]   s2_sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_sign <= 1'b0; s2_zsign <= 1'b0; s2_spec <= 1'b0;
      s2_spec_val <= '0; s2_exp <= '0; s2_sum <= '0;
    end else begin
      s2_sign     <= s1_sign;
      s2_zsign    <= s1_zsign;
      s2_spec     <= s1_spec;
      s2_spec_val <= s1_spec_val;
      s2_exp      <= s1_exp;
      s2_sum      <= sum_c;
    end
  end

  // ---------------- stage 3: normalize
  logic [LZ_W-1:0]   lz_c;
  logic [MANT_W-1:0] norm_c;
  logic signed [SE_W-1:0] nexp_c;

  always_comb begin
    lz_c = lzc(s2_sum[MANT_W-1:0]);
    if (s2_sum[MANT_W]) begin
      norm_c = {s2_sum[MANT_W:2], s2_sum[1] | s2_sum[0]};
      nexp_c = $signed({2'b00, s2_exp}) + 10'sd1;
    end else begin
      norm_c = s2_sum[MANT_W-1:0] << lz_c;
      nexp_c = $signed({2'b00, s2_exp}) - $signed({{(SE_W-LZ_W){1'b0}}, lz_c});
    end
  end

  logic              s3_sign, s3_zsign, s3_spec, s3_zero;
  logic [FP_W-1:0]   s3_spec_val;
  logic [MANT_W-1:0] s3_n;
  logic signed [SE_W-1:0] s3_e;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s3_sign <= 1'b0; s3_zsign <= 1'b0; s3_spec <= 1'b0; s3_zero <= 1'b0;
      s3_spec_val <= '0; s3_n <= '0; s3_e <= '0;
    end else begin
      s3_sign     <= s2_sign;
      s3_zsign    <= s2_zsign;
      s3_spec     <= s2_spec;
      s3_zero     <= (s2_sum == '0);
      s3_spec_val <= s2_spec_val;
      s3_n        <= norm_c;
      s3_e        <= nexp_c;
    end
  end

  // ---------------- stage 4: round to nearest even, pack
  logic                    rnd_up_c;
  logic [FRAC_W+1:0]       mant_c;
  logic [FRAC_W-1:0]       frac_c;
  logic signed [SE_W-1:0]  fexp_c;
  logic [FP_W-1:0]         res_c;

  always_comb begin
    rnd_up_c = s3_n[2] & (s3_n[1] | s3_n[0] | s3_n[3]);
    mant_c   = {1'b0, s3_n[MANT_W-1:GRD_W]} + {{(FRAC_W+1){1'b0}}, rnd_up_c};
    fexp_c   = s3_e + $signed({{(SE_W-1){1'b0}}, mant_c[FRAC_W+1]});
    frac_c   = mant_c[FRAC_W+1] ? mant_c[FRAC_W:1] : mant_c[FRAC_W-1:0];
    if (s3_spec)                 res_c = s3_spec_val;
    else if (s3_zero)            res_c = {s3_zsign, 31'd0};
    else if (fexp_c >= 10'sd255) res_c = {s3_sign, EXP_MAX, {FRAC_W{1'b0}}};
    else if (fexp_c <= 10'sd0)   res_c = {s3_sign, 31'd0};
    else                         res_c = {s3_sign, fexp_c[EXP_W-1:0], frac_c};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= '0;
    else         sum_o <= res_c;
  end
endmodule

// File: rtl/ps_radd_top.sv
module ps_radd_top
  import ps_radd_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [PS_W-1:0] src_hi_i,
  input  logic [PS_W-1:0] src_lo_i,
  output logic            valid_o,
  output logic [PS_W-1:0] res_o
);
  logic [LANES-1:0][PS_W-1:0] ops;
  assign ops = {src_hi_i, src_lo_i};  // lane 1 = upper result half

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fp32_add_pipe u_add (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .a_i   (ops[g][PS_W-1:FP_W]),
      .b_i   (ops[g][FP_W-1:0]),
      .sum_o (res_o[g*FP_W +: FP_W])
    );
  end

  ps_valid_delay #(.DEPTH(PIPE_LAT)) u_vld (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (valid_i),
    .q_o   (valid_o)
  );
endmodule

// File: rtl/ps_radd_chk.sv
module ps_radd_chk
  import ps_radd_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [PS_W-1:0] src_hi_i,
  input logic [PS_W-1:0] src_lo_i,
  input logic            valid_o,
  input logic [PS_W-1:0] res_o
);
  logic [2:0] warm_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          warm_q <= '0;
    else if (warm_q != 3'(PIPE_LAT))      warm_q <= warm_q + 1'b1;
  end
  assign warm = (warm_q == 3'(PIPE_LAT));

  logic hi_nan, lo_nan, lo_cancel, hi_negz;
  assign hi_nan    = fp_is_nan(src_hi_i[63:32]) | fp_is_nan(src_hi_i[31:0]);
  assign lo_nan    = fp_is_nan(src_lo_i[63:32]) | fp_is_nan(src_lo_i[31:0]);
  assign lo_cancel = fp_is_inf(src_lo_i[63:32]) & fp_is_inf(src_lo_i[31:0]) &
                     (src_lo_i[63] ^ src_lo_i[31]);
  assign hi_negz   = fp_is_zero(src_hi_i[63:32]) & fp_is_zero(src_hi_i[31:0]) &
                     src_hi_i[63] & src_hi_i[31];

  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (valid_o == $past(valid_i, 4))); // R4
  AST_NAN_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(hi_nan, 4)) |-> (res_o[63:32] == QNAN)); // R7
  AST_NAN_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(lo_nan, 4)) |-> (res_o[31:0] == QNAN)); // R7
  AST_INF_CANCEL_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(lo_cancel, 4)) |-> (res_o[31:0] == QNAN)); // R8
  AST_NEG_ZERO_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(hi_negz, 4)) |-> (res_o[63:32] == 32'h8000_0000)); // R9
endmodule

bind ps_radd_top ps_radd_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .src_hi_i(src_hi_i),
  .src_lo_i(src_lo_i),
  .valid_o (valid_o),
  .res_o   (res_o)
);

// File: tb/sim_ps_radd_top.sv
module sim_ps_radd_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] src_hi_i = '0;
  logic [63:0] src_lo_i = '0;
  logic        valid_o;
  logic [63:0] res_o;

  always #2 clk_i = ~clk_i;  // 250 MHz

  ps_radd_top u0 (.*);

  typedef struct {
    logic        v;
    logic [63:0] r;
    string       th;
    string       tl;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done  = 0;
  logic [31:0] seed  = 32'h1234_5678;

  // Exact wide-integer sum, then single-precision RNE with flush to zero.
  function automatic logic [31:0] rf(input logic [31:0] a, input logic [31:0] b);
    logic [299:0] va, vb, m, rem, half;
    logic [24:0]  keep;
    logic         rs;
    int ea, eb, emin, p, sh, e;
    ea = int'(a[30:23]);
    eb = int'(b[30:23]);
    if ((ea == 255 && a[22:0] != 0) || (eb == 255 && b[22:0] != 0)) return 32'h7FC0_0000;
    if (ea == 255 && eb == 255) return (a[31] != b[31]) ? 32'h7FC0_0000 : a;
    if (ea == 255) return a;
    if (eb == 255) return b;
    if (ea == 0 && eb == 0) return {a[31] & b[31], 31'd0};
    if (ea == 0) return b;
    if (eb == 0) return a;
    emin = (ea < eb) ? ea : eb;
    va = {276'd0, 1'b1, a[22:0]} << (ea - emin);
    vb = {276'd0, 1'b1, b[22:0]} << (eb - emin);
    if (a[31] == b[31]) begin m = va + vb; rs = a[31]; end
    else if (va > vb)   begin m = va - vb; rs = a[31]; end
    else                begin m = vb - va; rs = b[31]; end
    if (m == 0) return 32'h0;
    p = 0;
    for (int i = 0; i < 300; i++) if (m[i]) p = i;
    e = p + emin - 23;
    if (p > 23) begin
      sh   = p - 23;
      keep = 25'(m >> sh);
      rem  = m & ((300'd1 << sh) - 300'd1);
      half = 300'd1 << (sh - 1);
      if (rem > half || (rem == half && keep[0])) keep = keep + 25'd1;
      if (keep[24]) begin keep = keep >> 1; e = e + 1; end
    end else begin
      keep = 25'(m << (23 - p));
    end
    if (e >= 255) return {rs, 8'hFF, 23'd0};
    if (e <= 0)   return {rs, 31'd0};
    return {rs, 8'(e), keep[22:0]};
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // One cycle: compare current output, then drive the next operands.
  task automatic step(input logic v, input logic [63:0] hi, input logic [63:0] lo,
                      input string th, input string tl);
    exp_t e, x;
    @(negedge clk_i);
    x = q.pop_front();
    chk("R4 valid", {63'd0, valid_o}, {63'd0, x.v});
    chk(x.th, {32'd0, res_o[63:32]}, {32'd0, x.r[63:32]});
    chk(x.tl, {32'd0, res_o[31:0]},  {32'd0, x.r[31:0]});
    valid_i  = v;
    src_hi_i = hi;
    src_lo_i = lo;
    e.v  = v;
    e.r  = {rf(hi[63:32], hi[31:0]), rf(lo[63:32], lo[31:0])};
    e.th = th;
    e.tl = tl;
    q.push_back(e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    exp_t z;
    logic [31:0] a, b, c, d;
    z.v = 0; z.r = '0; z.th = "R1 idle"; z.tl = "R2 idle";
    repeat (4) q.push_back(z);
    repeat (3) @(negedge clk_i);
    chk("R11 reset valid", {63'd0, valid_o}, 64'd0);
    chk("R11 reset data", res_o, 64'd0);
    rst_ni = 1'b1;
    @(posedge clk_i);

    step(1, {32'h3F80_0000, 32'h4000_0000}, {32'h3FC0_0000, 32'hBE80_0000}, "R1 basic", "R2 basic");
    step(1, {32'h4120_0000, 32'hC040_0000}, {32'h4000_0000, 32'h4000_0000}, "R1 mixed", "R2 equal");
    step(1, {32'h3F80_0000, 32'h3380_0000}, {32'h3F80_0001, 32'h3380_0000}, "R3 tie even", "R3 tie odd");
    step(1, {32'h3F80_0000, 32'h3380_0001}, {32'h3F80_0000, 32'h3300_0000}, "R3 above half", "R3 below half");
    step(0, {32'h0000_0001, 32'h3F80_0000}, {32'h0000_0005, 32'h8000_0003}, "R6 denorm in", "R6 denorm pair");
    step(1, {32'h0080_0001, 32'h8080_0000}, {32'h8080_0001, 32'h0080_0000}, "R6 flush pos", "R6 flush neg");
    step(1, {32'h7FA0_0000, 32'h3F80_0000}, {32'hFFC0_0001, 32'h7F80_0000}, "R7 snan", "R7 nan inf");
    step(1, {32'h7F80_0000, 32'h40A0_0000}, {32'h7F80_0000, 32'hFF80_0000}, "R8 inf fin", "R8 inf cancel");
    step(1, {32'hFF80_0000, 32'hFF80_0000}, {32'h0000_0000, 32'hFF80_0000}, "R8 neg inf", "R8 zero inf");
    step(1, {32'h8000_0000, 32'h8000_0000}, {32'h0000_0000, 32'h8000_0000}, "R9 neg zeros", "R9 mixed zeros");
    step(1, {32'h4040_0000, 32'hC040_0000}, {32'hC040_0000, 32'h4040_0000}, "R9 cancel", "R9 cancel rev");
    step(1, {32'h7F7F_FFFF, 32'h7F7F_FFFF}, {32'hFF7F_FFFF, 32'hFF00_0000}, "R10 ovf pos", "R10 ovf neg");
    step(1, {32'h7149_F2CA, 32'h3F80_0000}, {32'h3F80_0001, 32'hBF80_0000}, "R1 far exp", "R2 long shift");
    repeat (3) step(0, '0, '0, "R1 gap", "R2 gap");

    for (int i = 0; i < 300; i++) begin
      seed = nxt(seed); a = seed;
      seed = nxt(seed); b = seed;
      seed = nxt(seed); c = seed;
      seed = nxt(seed); d = seed;
      case (i % 3)
        1: begin b = {~a[31], a[30:23], b[22:0]}; d = {~c[31], c[30:23], d[22:0]}; end
        2: begin b = {a[31], a[30:24], b[23:0]};  d = {c[31], c[30:25], d[24:0]}; end
        default: ;
      endcase
      step((i % 7) != 3, {a, b}, {c, d}, "R5 stream hi", "R5 stream lo");
    end
    repeat (6) step(0, '0, '0, "R4 drain hi", "R4 drain lo");
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule